// File: doc/BRIEF.md
# Integer Compare and Trap Unit

This block compares two 64-bit integer operands and turns the relation into one of two results. In compare mode it gives a 4-bit condition field: less-than, greater-than, equal, and a copy of the summary-overflow bit. In trap mode it ANDs a five-bit relation vector with a five-bit condition mask and raises a trap request if any bit of the result is set. A signed/unsigned flag and a word/doubleword flag select the kind of comparison. When the word flag is set, only the low 32 bits of each operand take part.

The ordering comes from one subtraction, B + ~A + 1, through the shared adder. Equality comes from a direct comparison of the two operands. Less-than and greater-than are formed from the sign bit of the difference, the carry out of the selected width, and the sign bits of the operands. A caller presents an operation with `valid_i`. The result appears on the registered outputs one cycle later. Writing the condition register and taking the trap belong to the caller.

Top module: `cmp_trap_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `res_valid_o`, `crf_o` and `trap_o` are all zero.
- R2: `res_valid_o` is high in exactly the cycle after a cycle in which `valid_i` was high. With `valid_i` low, `crf_o` and `trap_o` become zero in the next cycle.
- R3: In doubleword mode (`word_i`=0), an unsigned compare (`signed_i`=0) reports A<B, A>B or A==B over all 64 bits.
- R4: In doubleword mode, a signed compare (`signed_i`=1) treats both operands as two's-complement 64-bit values.
- R5: In word mode (`word_i`=1), the compare and the equality test use only bits 31:0 of each operand. Bits 63:32 have no effect on `crf_o` or `trap_o`.
- R6: In compare mode (`trap_sel_i`=0), `crf_o` is {LT, GT, EQ, SO}, with bit 3 = A<B, bit 2 = A>B, bit 1 = A==B, and bit 0 = `so_i` as sampled with the operation.
- R7: In trap mode (`trap_sel_i`=1), the relation vector is bit 4 = signed A<B, bit 3 = signed A>B, bit 2 = A==B, bit 1 = unsigned A<B, bit 0 = unsigned A>B. `trap_o` is high when any bit of (vector AND `to_i`) is 1. `signed_i` has no effect in trap mode.
- R8: A trap-mode operation gives `crf_o`=0, and `to_i`=0 never traps. A compare-mode operation never raises `trap_o`.
- R9: In compare mode, exactly one of LT, GT and EQ is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Operation present this cycle |
| op_a_i | input | 64 | First operand A |
| op_b_i | input | 64 | Second operand B |
| signed_i | input | 1 | 1 = signed compare (compare mode only) |
| word_i | input | 1 | 1 = use the low 32 bits only |
| trap_sel_i | input | 1 | 1 = trap test, 0 = compare |
| to_i | input | 5 | Trap condition mask, same bit order as the relation vector |
| so_i | input | 1 | Summary-overflow bit copied into the condition field |
| res_valid_o | output | 1 | Result valid, one cycle after `valid_i` |
| crf_o | output | 4 | Condition field {LT, GT, EQ, SO} |
| trap_o | output | 1 | Trap request |

## Verification
The checker assumes that every input is sampled only in a cycle where `valid_i` is high. It relates each registered result to the operands, flags and mask of the previous cycle, so it also assumes that nothing else changes the outputs between operations. The stimulus drives each operation for a single cycle, away from the clock edge. It returns `valid_i` to zero before the result is read, so every result has exactly one source cycle. The operand set covers the sign and carry boundaries at bit 31 and bit 63. Pairs that differ only above bit 31 test the word-mode masking.

// File: rtl/cmp_trap_pkg.sv
// Shared types and field positions for the compare/trap unit.
// Assumes the relation vector order is fixed, because the trap mask
// is decoded against it bit for bit.
package cmp_trap_pkg;

    // Relation vector: bit 4 down to bit 0
    typedef struct packed {
        logic slt;  // signed A < B
        logic sgt;  // signed A > B
        logic eq;   // A == B
        logic ult;  // unsigned A < B
        logic ugt;  // unsigned A > B
    } rel_t;

    localparam int REL_W  = 5;
    localparam int CRF_W  = 4;
    localparam int CRF_LT = 3;
    localparam int CRF_GT = 2;
    localparam int CRF_EQ = 1;
    localparam int CRF_SO = 0;

endpackage

// File: rtl/cmp_sub_core.sv
// Subtractor for the compare path: forms B + ~A + 1 as a split add.
// It gives the carry out of the low half (word compare) and of the
// full width (doubleword compare). Assumes 0 < HALF_W < DATA_W.
module cmp_sub_core #(
    parameter int DATA_W = 64,
    parameter int HALF_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] diff_o,
    output logic              carry_lo_o,
    output logic              carry_hi_o
);
    localparam int UP_W = DATA_W - HALF_W;

    logic [HALF_W:0] lo_sum;
    logic [UP_W:0]   hi_sum;

    // Low half: ~A + B + 1, keeping the carry out of the top bit of the half
    always_comb begin
        lo_sum = {1'b0, ~a_i[HALF_W-1:0]} + {1'b0, b_i[HALF_W-1:0]}
               + {{HALF_W{1'b0}}, 1'b1};
    end

    // Upper part: adds in the carry from the low half
    always_comb begin
        hi_sum = {1'b0, ~a_i[DATA_W-1:HALF_W]} + {1'b0, b_i[DATA_W-1:HALF_W]}
               + {{UP_W{1'b0}}, lo_sum[HALF_W]};
    end

    assign diff_o     = {hi_sum[UP_W-1:0], lo_sum[HALF_W-1:0]};
    assign carry_lo_o = lo_sum[HALF_W];
    assign carry_hi_o = hi_sum[UP_W];
endmodule

// File: rtl/cmp_rel_gen.sv
// Builds the five-bit relation vector for one width, from the sign
// bit of B-A, the carry out of that width, the operand sign bits and
// the equality flag. Assumes carry=1 exactly when B >= A unsigned.
module cmp_rel_gen
    import cmp_trap_pkg::*;
(
    input  logic a_msb_i,
    input  logic b_msb_i,
    input  logic d_msb_i,
    input  logic carry_i,
    input  logic eq_i,
    output rel_t rel_o
);
    // Derive the signed and unsigned relations without a magnitude comparator
    always_comb begin
        rel_o.eq  = eq_i;
        rel_o.ugt = ~carry_i;
        rel_o.ult = carry_i & ~eq_i;
        if (a_msb_i != b_msb_i) begin
            rel_o.slt = a_msb_i;
            rel_o.sgt = b_msb_i;
        end else begin
            rel_o.sgt = d_msb_i;
            rel_o.slt = ~d_msb_i & ~eq_i;
        end
    end
endmodule

// File: rtl/cmp_trap_unit.sv
// Compare/trap unit top. One subtraction and a direct equality test
// produce a relation vector for both widths. The selected vector
// feeds either the condition field or the trap test. All outputs are
// registered (one cycle of latency). Assumes inputs are meaningful
// only while valid_i is high.
module cmp_trap_unit
    import cmp_trap_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] op_a_i,
    input  logic [DATA_W-1:0] op_b_i,
    input  logic              signed_i,
    input  logic              word_i,
    input  logic              trap_sel_i,
    input  logic [REL_W-1:0]  to_i,
    input  logic              so_i,
    output logic              res_valid_o,
    output logic [CRF_W-1:0]  crf_o,
    output logic              trap_o
);
    localparam int N_WIDTHS = 2;

    logic [DATA_W-1:0] diff;
    logic              carry_lo, carry_hi;
    logic              eq_lo, eq_hi;
    logic [N_WIDTHS-1:0] w_eq, w_carry, w_amsb, w_bmsb, w_dmsb;
    rel_t              w_rel [N_WIDTHS];
    rel_t              rel_sel;
    logic [CRF_W-1:0]  crf_nxt;
    logic              trap_nxt;

    cmp_sub_core #(.DATA_W(DATA_W), .HALF_W(WORD_W)) sub_i (
        .a_i       (op_a_i),
        .b_i       (op_b_i),
        .diff_o    (diff),
        .carry_lo_o(carry_lo),
        .carry_hi_o(carry_hi)
    );

    // Direct equality, split so the word test reuses the low half
    always_comb begin
        eq_lo = (op_a_i[WORD_W-1:0] == op_b_i[WORD_W-1:0]);
        eq_hi = (op_a_i[DATA_W-1:WORD_W] == op_b_i[DATA_W-1:WORD_W]);
    end

    // Per-width inputs: index 0 = word, index 1 = doubleword
    always_comb begin
        w_eq[0]    = eq_lo;
        w_carry[0] = carry_lo;
        w_amsb[0]  = op_a_i[WORD_W-1];
        w_bmsb[0]  = op_b_i[WORD_W-1];
        w_dmsb[0]  = diff[WORD_W-1];
        w_eq[1]    = eq_lo & eq_hi;
        w_carry[1] = carry_hi;
        w_amsb[1]  = op_a_i[DATA_W-1];
        w_bmsb[1]  = op_b_i[DATA_W-1];
        w_dmsb[1]  = diff[DATA_W-1];
    end

    for (genvar g = 0; g < N_WIDTHS; g++) begin : g_width
        cmp_rel_gen rel_i (
            .a_msb_i(w_amsb[g]),
            .b_msb_i(w_bmsb[g]),
            .d_msb_i(w_dmsb[g]),
            .carry_i(w_carry[g]),
            .eq_i   (w_eq[g]),
            .rel_o  (w_rel[g])
        );
    end

    // Pick the relation vector for the requested width
    always_comb begin
        rel_sel = word_i ? w_rel[0] : w_rel[1];
    end

    // Form the condition field and the trap decision from one vector
    always_comb begin
        crf_nxt  = '0;
        trap_nxt = 1'b0;
        if (valid_i) begin
            if (trap_sel_i) begin
                trap_nxt = |(rel_sel & to_i);
            end else begin
                crf_nxt[CRF_LT] = signed_i ? rel_sel.slt : rel_sel.ult;
                crf_nxt[CRF_GT] = signed_i ? rel_sel.sgt : rel_sel.ugt;
                crf_nxt[CRF_EQ] = rel_sel.eq;
                crf_nxt[CRF_SO] = so_i;
            end
        end
    end

    // Output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid_o <= 1'b0;
            crf_o       <= '0;
            trap_o      <= 1'b0;
        end else begin
            res_valid_o <= valid_i;
            crf_o       <= crf_nxt;
            trap_o      <= trap_nxt;
        end
    end
endmodule

// File: rtl/cmp_trap_unit_chk.sv
// Checker for cmp_trap_unit. It relates the registered outputs to the
// inputs of the previous cycle and is attached with the bind below.
module cmp_trap_unit_chk
    import cmp_trap_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic [DATA_W-1:0] op_a_i,
    input logic [DATA_W-1:0] op_b_i,
    input logic              signed_i,
    input logic              word_i,
    input logic              trap_sel_i,
    input logic [REL_W-1:0]  to_i,
    input logic              so_i,
    input logic              res_valid_o,
    input logic [CRF_W-1:0]  crf_o,
    input logic              trap_o
);
    // R2
    res_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> $past(valid_i));

    // R2
    res_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(valid_i) && $past(rst_n)) |-> res_valid_o);

    // R9
    crf_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !$past(trap_sel_i)) |-> ($countones(crf_o[CRF_LT:CRF_EQ]) == 1));

    // R6
    crf_so_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !$past(trap_sel_i)) |-> (crf_o[CRF_SO] == $past(so_i)));

    // R8
    trap_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (res_valid_o && $past(trap_sel_i) && ($past(to_i) != '0)));

    // R8
    trap_crf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && $past(trap_sel_i)) |-> (crf_o == '0));

    // R5
    eq_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && crf_o[CRF_EQ])
            |-> ($past(op_a_i[WORD_W-1:0]) == $past(op_b_i[WORD_W-1:0])));

    // R3
    eq_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && crf_o[CRF_EQ] && !$past(word_i)) |-> ($past(op_a_i) == $past(op_b_i)));
endmodule

bind cmp_trap_unit cmp_trap_unit_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W)) chk_i (.*);

// File: tb/cmp_trap_unit_tb_top.sv
// Sweep bench: every pair from a set of boundary operands, in every
// compare mode and against every trap mask. Expected values come from
// widened signed arithmetic.
module cmp_trap_unit_tb_top;
    localparam int NV = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [63:0] op_a_i = '0, op_b_i = '0;
    logic        signed_i = 1'b0, word_i = 1'b0, trap_sel_i = 1'b0, so_i = 1'b0;
    logic [4:0]  to_i = '0;
    logic        res_valid_o, trap_o;
    logic [3:0]  crf_o;

    int checks = 0;
    int errors = 0;
    logic [63:0] vals [NV];

    always #2.5 clk = ~clk;

    cmp_trap_unit dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i),
        .op_a_i(op_a_i), .op_b_i(op_b_i), .signed_i(signed_i), .word_i(word_i),
        .trap_sel_i(trap_sel_i), .to_i(to_i), .so_i(so_i),
        .res_valid_o(res_valid_o), .crf_o(crf_o), .trap_o(trap_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference relation vector {slt, sgt, eq, ult, ugt}
    function automatic logic [4:0] ref_rel(input logic [63:0] a, input logic [63:0] b,
                                           input logic word);
        logic signed [64:0] sa, sb, ua, ub;
        if (word) begin
            sa = {{33{a[31]}}, a[31:0]};  sb = {{33{b[31]}}, b[31:0]};
            ua = {33'd0, a[31:0]};        ub = {33'd0, b[31:0]};
        end else begin
            sa = {a[63], a};  sb = {b[63], b};
            ua = {1'b0, a};   ub = {1'b0, b};
        end
        return {sa < sb, sa > sb, ua == ub, ua < ub, ua > ub};
    endfunction

    // Drive one operation for one cycle; result read at the next falling edge
    task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic sg,
                          input logic wd, input logic tr, input logic [4:0] to,
                          input logic so);
        @(negedge clk);
        op_a_i = a; op_b_i = b; signed_i = sg; word_i = wd;
        trap_sel_i = tr; to_i = to; so_i = so; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        op_a_i = ~a; op_b_i = b ^ 64'h5555;
    endtask

    initial begin
        vals[0]  = 64'h0;
        vals[1]  = 64'h1;
        vals[2]  = 64'hFFFF_FFFF_FFFF_FFFF;
        vals[3]  = 64'h7FFF_FFFF_FFFF_FFFF;
        vals[4]  = 64'h8000_0000_0000_0000;
        vals[5]  = 64'h0000_0000_FFFF_FFFF;
        vals[6]  = 64'h0000_0000_8000_0000;
        vals[7]  = 64'h0000_0000_7FFF_FFFF;
        vals[8]  = 64'h0000_0001_0000_0000;
        vals[9]  = 64'h1234_5678_0000_0001;
        vals[10] = 64'hFFFF_FFFF_0000_0000;
        vals[11] = 64'h8000_0000_8000_0000;
        vals[12] = 64'h0000_0001_0000_0001;
        vals[13] = 64'hDEAD_BEEF_7FFF_FFFF;
    end

    initial begin
        // Watchdog
        #900000;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [4:0] r;
        logic [3:0] exp_crf;
        logic       exp_trap;
        // R1: reset state, even with valid_i held high
        valid_i = 1'b1;
        repeat (3) @(negedge clk);
        check(res_valid_o == 0 && crf_o == 0 && trap_o == 0, "R1",
              {res_valid_o, crf_o, trap_o}, 0);
        valid_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(res_valid_o == 0 && crf_o == 0 && trap_o == 0, "R1",
              {res_valid_o, crf_o, trap_o}, 0);

        // R3 R4 R5 R6 R9: compare sweep
        for (int i = 0; i < NV; i++)
            for (int j = 0; j < NV; j++)
                for (int m = 0; m < 4; m++) begin
                    logic sg, wd, so;
                    sg = m[0]; wd = m[1]; so = (i + j) % 2 == 1;
                    run_op(vals[i], vals[j], sg, wd, 1'b0, 5'h1F, so);
                    r = ref_rel(vals[i], vals[j], wd);
                    exp_crf = {sg ? r[4] : r[1], sg ? r[3] : r[0], r[2], so};
                    check(res_valid_o == 1'b1, "R2", res_valid_o, 1);
                    check(crf_o == exp_crf,
                          wd ? "R5/R6 word compare" : (sg ? "R4/R6 signed compare"
                                                          : "R3/R6 unsigned compare"),
                          crf_o, exp_crf);
                    check(trap_o == 1'b0, "R8 no trap in compare", trap_o, 0);
                end

        // R7 R8: trap sweep over every mask; signed_i toggled to show no effect
        for (int i = 0; i < NV; i++)
            for (int j = 0; j < NV; j++)
                for (int wd = 0; wd < 2; wd++)
                    for (int t = 0; t < 32; t++) begin
                        run_op(vals[i], vals[j], t[0] ^ i[0], wd[0], 1'b1, t[4:0], 1'b1);
                        r = ref_rel(vals[i], vals[j], wd[0]);
                        exp_trap = |(r & t[4:0]);
                        check(trap_o == exp_trap, "R7 trap", trap_o, exp_trap);
                        check(crf_o == 4'b0, "R8 crf zero in trap", crf_o, 0);
                    end

        // R2: idle cycle after an operation clears outputs
        run_op(64'd3, 64'd3, 1'b0, 1'b0, 1'b0, 5'h0, 1'b1);
        @(negedge clk);
        check(res_valid_o == 0 && crf_o == 0 && trap_o == 0, "R2 idle",
              {res_valid_o, crf_o, trap_o}, 0);

        // R5: upper bits differ only; word mode reports equal
        run_op(64'hAAAA_0000_0000_0042, 64'h5555_0000_0000_0042, 1'b1, 1'b1, 1'b0, 5'h0, 1'b0);
        check(crf_o == 4'b0010, "R5 upper ignored", crf_o, 4'b0010);
        run_op(64'hAAAA_0000_0000_0042, 64'h5555_0000_0000_0042, 1'b1, 1'b1, 1'b1, 5'h1B, 1'b0);
        check(trap_o == 1'b0, "R5 upper ignored in trap", trap_o, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule